// File: doc/BRIEF.md
# Prioritized Interrupt Controller With Vectors

This block gathers interrupt requests from sixteen maskable peripheral sources: an analog-to-digital converter, transmit and receive for two serial ports, eight timers and three external pins. It also gathers five special sources: a system reset request, a debug break, a watchdog, a divide-by-zero trap and a software break. Each maskable source owns a small control register. The register holds a 3-bit software priority level and a pending-request bit. Software writes it through a single-cycle write port. A hardware pulse from the peripheral also sets the pending bit.

Every cycle the block picks one winner. The special sources come first, in a fixed order, and are never masked. Below them, a maskable source takes part only if its level is above the processor's current priority level and interrupts are enabled. The highest level wins, and a tie goes to the source with the higher vector. The block drives a request-valid flag and the winner's 16-bit vector address. When the processor acknowledges a maskable winner, hardware clears that source's pending bit.

Top module: `intc_prio`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `irq_valid` is 0 and `irq_vector` is 0. Reset clears every level and every pending bit.
- R2: When `wr_en` is high, control register `wr_sel` is written at the clock edge. `wr_data[2:0]` becomes the level and `wr_data[3]` becomes the pending bit. The outputs show the result from the next cycle.
- R3: A maskable source is eligible only when all of the following hold: its pending bit is set, its level is strictly greater than `cpu_ipl`, and `int_dis` is 0. A level of 0 is therefore never eligible.
- R4: Maskable source index i has vector 0xFFD6 + 2*i. The index order is:
  - 0: converter
  - 1: serial port 1 transmit
  - 2: serial port 1 receive
  - 3: serial port 0 transmit
  - 4: serial port 0 receive
  - 5 to 7: timers B2, B1, B0
  - 8 to 12: timers A4 down to A0
  - 13 to 15: external pins 2, 1, 0
- R5: Among eligible sources, the one with the highest level wins. When levels are equal, the higher index wins.
- R6: The special sources override everything, in this order: `rst_req` (vector 0xFFFE), `dbg_req` (0xFFF8), `wdt_req` (0xFFF6), `zdiv_req` (0xFFFC), `brk_req` (0xFFFA). Neither `cpu_ipl` nor `int_dis` affects them.
- R7: An `ack` while `irq_valid` shows a maskable winner clears that source's pending bit at the clock edge, and the next winner appears in the following cycle. An `ack` while nothing is valid, or while a special source is shown, changes no pending bit.
- R8: A pulse on `src_irq[i]` sets pending bit i. A pulse in the same cycle as a write to source i, or as an acknowledge of source i, leaves the bit set.
- R9: Writing 0 to `wr_data[3]` cancels a pending request of that source.
- R10: When there is no winner, `irq_valid` is 0 and `irq_vector` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_sel | input | 4 | Index of the control register to write |
| wr_data | input | 4 | Level in [2:0], pending bit in [3] |
| src_irq | input | 16 | Peripheral request pulses, one per maskable source |
| rst_req | input | 1 | System reset request (special) |
| dbg_req | input | 1 | Debug break request (special) |
| wdt_req | input | 1 | Watchdog request (special) |
| zdiv_req | input | 1 | Divide-by-zero trap (special) |
| brk_req | input | 1 | Software break request (special) |
| cpu_ipl | input | 3 | Processor's current interrupt priority level |
| int_dis | input | 1 | Global disable for maskable sources |
| ack | input | 1 | Processor accepts the shown interrupt |
| irq_valid | output | 1 | A winner is shown |
| irq_vector | output | 16 | Winner's vector address |

## Verification
Every result is due exactly one clock edge after the inputs that cause it. This holds for a register write, a request pulse, an acknowledge, a change of `cpu_ipl`, `int_dis` or a special input, and a reset. The reason is that the winner is chosen from the next-state register values and then registered once. The bench therefore drives all inputs just after a falling edge. It updates its own model of the control registers, waits for the rising edge, and compares `irq_valid` and `irq_vector` at the following falling edge. Pulse inputs are removed only after that comparison.

// File: rtl/intc_prio_pkg.sv
package intc_prio_pkg;
    localparam int          NSRC     = 16;
    localparam int          LVL_W    = 3;
    localparam int          VEC_W    = 16;
    localparam logic [15:0] VEC_BASE = 16'hFFD6;
    localparam logic [15:0] VEC_RST  = 16'hFFFE;
    localparam logic [15:0] VEC_DBG  = 16'hFFF8;
    localparam logic [15:0] VEC_WDT  = 16'hFFF6;
    localparam logic [15:0] VEC_ZDIV = 16'hFFFC;
    localparam logic [15:0] VEC_BRK  = 16'hFFFA;
endpackage

// File: rtl/intc_ctl_bank.sv
module intc_ctl_bank #(
    parameter int NSRC  = 16,
    parameter int LVL_W = 3,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_sel,
    input  logic [LVL_W-1:0]            wr_lvl,
    input  logic                        wr_pend,
    input  logic                        clr_en,
    input  logic [IDX_W-1:0]            clr_idx,
    input  logic [NSRC-1:0]             set_mask,
    output logic [NSRC-1:0]             pend_d,
    output logic [NSRC-1:0][LVL_W-1:0]  lvl_d,
    output logic [NSRC-1:0]             pend_q,
    output logic [NSRC-1:0][LVL_W-1:0]  lvl_q
);
    typedef struct packed {
        logic [NSRC-1:0]            pend;
        logic [NSRC-1:0][LVL_W-1:0] lvl;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en) begin
            st_d.pend[clr_idx] = 1'b0;
        end
        if (wr_en) begin
            st_d.lvl[wr_sel]  = wr_lvl;
            st_d.pend[wr_sel] = wr_pend;
        end
        st_d.pend = st_d.pend | set_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_d = st_d.pend;
    assign lvl_d  = st_d.lvl;
    assign pend_q = st_q.pend;
    assign lvl_q  = st_q.lvl;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int NSRC  = 16,
    parameter int LVL_W = 3,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]            pend,
    input  logic [NSRC-1:0][LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0]           ipl,
    input  logic                       masked,
    output logic                       found,
    output logic [IDX_W-1:0]           win_idx
);
    logic [LVL_W-1:0] best_lvl;

    always_comb begin
        found    = 1'b0;
        best_lvl = '0;
        win_idx  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (!masked && pend[i] && (lvl[i] > ipl) &&
                (!found || lvl[i] >= best_lvl)) begin
                found    = 1'b1;
                best_lvl = lvl[i];
                win_idx  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/intc_prio.sv
module intc_prio
    import intc_prio_pkg::*;
#(
    parameter int NSRC_P  = NSRC,
    parameter int LVL_W_P = LVL_W,
    localparam int IDX_W = $clog2(NSRC_P)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_sel,
    input  logic [LVL_W_P:0]     wr_data,
    input  logic [NSRC_P-1:0]    src_irq,
    input  logic                 rst_req,
    input  logic                 dbg_req,
    input  logic                 wdt_req,
    input  logic                 zdiv_req,
    input  logic                 brk_req,
    input  logic [LVL_W_P-1:0]   cpu_ipl,
    input  logic                 int_dis,
    input  logic                 ack,
    output logic                 irq_valid,
    output logic [VEC_W-1:0]     irq_vector
);
    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vector;
        logic [IDX_W-1:0] idx;
        logic             maskable;
    } out_t;

    out_t out_d, out_q;

    logic [NSRC_P-1:0]              pend_d, pend_q;
    logic [NSRC_P-1:0][LVL_W_P-1:0] lvl_d, lvl_q;
    logic                           arb_found;
    logic [IDX_W-1:0]               arb_idx;
    logic                           clr_en;

    assign clr_en = ack && out_q.valid && out_q.maskable;

    intc_ctl_bank #(.NSRC(NSRC_P), .LVL_W(LVL_W_P)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_lvl   (wr_data[LVL_W_P-1:0]),
        .wr_pend  (wr_data[LVL_W_P]),
        .clr_en   (clr_en),
        .clr_idx  (out_q.idx),
        .set_mask (src_irq),
        .pend_d   (pend_d),
        .lvl_d    (lvl_d),
        .pend_q   (pend_q),
        .lvl_q    (lvl_q)
    );

    intc_arbiter #(.NSRC(NSRC_P), .LVL_W(LVL_W_P)) u_arb (
        .pend    (pend_d),
        .lvl     (lvl_d),
        .ipl     (cpu_ipl),
        .masked  (int_dis),
        .found   (arb_found),
        .win_idx (arb_idx)
    );

    always_comb begin
        out_d = '0;
        if (rst_req) begin
            out_d.valid  = 1'b1;
            out_d.vector = VEC_RST;
        end else if (dbg_req) begin
            out_d.valid  = 1'b1;
            out_d.vector = VEC_DBG;
        end else if (wdt_req) begin
            out_d.valid  = 1'b1;
            out_d.vector = VEC_WDT;
        end else if (zdiv_req) begin
            out_d.valid  = 1'b1;
            out_d.vector = VEC_ZDIV;
        end else if (brk_req) begin
            out_d.valid  = 1'b1;
            out_d.vector = VEC_BRK;
        end else if (arb_found) begin
            out_d.valid    = 1'b1;
            out_d.maskable = 1'b1;
            out_d.idx      = arb_idx;
            out_d.vector   = VEC_BASE + (VEC_W'(arb_idx) << 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_valid  = out_q.valid;
    assign irq_vector = out_q.vector;
endmodule

// File: rtl/intc_prio_checker.sv
module intc_prio_checker #(
    parameter int NSRC  = 16,
    parameter int LVL_W = 3,
    localparam int IDX_W = $clog2(NSRC)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ack,
    input logic                       wr_en,
    input logic [NSRC-1:0]            src_irq,
    input logic                       int_dis,
    input logic [LVL_W-1:0]           cpu_ipl,
    input logic                       any_special,
    input logic                       rst_req,
    input logic                       irq_valid,
    input logic [15:0]                irq_vector,
    input logic                       win_mask,
    input logic [IDX_W-1:0]           win_idx,
    input logic [NSRC-1:0]            pend_q,
    input logic [NSRC-1:0][LVL_W-1:0] lvl_q
);
    // R3: with maskable sources disabled and no special source, nothing is shown
    assert_mask_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (int_dis && !any_special) |=> !irq_valid);

    // R3: a shown maskable winner has a level above the priority level it was judged against
    assert_level_above_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && win_mask) |-> (lvl_q[win_idx] > $past(cpu_ipl)));

    // R6: a reset request is always shown next, with its vector
    assert_reset_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (irq_valid && irq_vector == 16'hFFFE));

    // R7: acknowledging a maskable winner clears its pending bit
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_valid && win_mask && !wr_en && !src_irq[win_idx])
            |=> !pend_q[$past(win_idx)]);

    // R10: no winner means a zero vector
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_vector == 16'h0000));

    // R4: shown vectors are even, two bytes per entry
    assert_even_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !irq_vector[0]);
endmodule

bind intc_prio intc_prio_checker #(.NSRC(NSRC_P), .LVL_W(LVL_W_P)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack         (ack),
    .wr_en       (wr_en),
    .src_irq     (src_irq),
    .int_dis     (int_dis),
    .cpu_ipl     (cpu_ipl),
    .any_special (rst_req | dbg_req | wdt_req | zdiv_req | brk_req),
    .rst_req     (rst_req),
    .irq_valid   (irq_valid),
    .irq_vector  (irq_vector),
    .win_mask    (out_q.maskable),
    .win_idx     (out_q.idx),
    .pend_q      (pend_q),
    .lvl_q       (lvl_q)
);

// File: tb/intc_prio_test.sv
module intc_prio_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  wr_sel;
    logic [3:0]  wr_data;
    logic [15:0] src_irq;
    logic        rst_req, dbg_req, wdt_req, zdiv_req, brk_req;
    logic [2:0]  cpu_ipl;
    logic        int_dis;
    logic        ack;
    logic        irq_valid;
    logic [15:0] irq_vector;

    always #4 clk = ~clk;

    intc_prio uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .src_irq(src_irq), .rst_req(rst_req), .dbg_req(dbg_req), .wdt_req(wdt_req),
        .zdiv_req(zdiv_req), .brk_req(brk_req), .cpu_ipl(cpu_ipl), .int_dis(int_dis),
        .ack(ack), .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [2:0]  m_lvl [16];
    logic        m_pend[16];
    logic        e_valid;
    logic [15:0] e_vec;
    int          e_idx;
    logic        e_mask;

    task automatic calc_exp();
        int best = -1;
        logic [2:0] bl = 3'd0;
        e_valid = 1'b1;
        e_mask  = 1'b0;
        e_idx   = 0;
        if (rst_req)       e_vec = 16'hFFFE;
        else if (dbg_req)  e_vec = 16'hFFF8;
        else if (wdt_req)  e_vec = 16'hFFF6;
        else if (zdiv_req) e_vec = 16'hFFFC;
        else if (brk_req)  e_vec = 16'hFFFA;
        else begin
            for (int i = 0; i < 16; i++) begin
                if (!int_dis && m_pend[i] && m_lvl[i] > cpu_ipl && (best < 0 || m_lvl[i] >= bl)) begin
                    best = i;
                    bl   = m_lvl[i];
                end
            end
            if (best < 0) begin
                e_valid = 1'b0;
                e_vec   = 16'h0000;
            end else begin
                e_mask = 1'b1;
                e_idx  = best;
                e_vec  = 16'hFFD6 + 16'(2 * best);
            end
        end
    endtask

    task automatic check(string tag);
        checks++;
        if (irq_valid !== e_valid || irq_vector !== e_vec) begin
            errors++;
            $display("FAIL %s: valid=%0b vector=%h expected valid=%0b vector=%h",
                     tag, irq_valid, irq_vector, e_valid, e_vec);
        end
    endtask

    task automatic step(string tag);
        if (ack && e_valid && e_mask) m_pend[e_idx] = 1'b0;
        if (wr_en) begin
            m_lvl[wr_sel]  = wr_data[2:0];
            m_pend[wr_sel] = wr_data[3];
        end
        for (int i = 0; i < 16; i++) if (src_irq[i]) m_pend[i] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        calc_exp();
        check(tag);
        wr_en   = 1'b0;
        src_irq = '0;
        ack     = 1'b0;
    endtask

    task automatic wr(int sel, logic [3:0] data, string tag);
        wr_en   = 1'b1;
        wr_sel  = 4'(sel);
        wr_data = data;
        step(tag);
    endtask

    task automatic drain(string tag);
        for (int n = 0; n < 20; n++) begin
            if (!e_valid) break;
            ack = 1'b1;
            step(tag);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 16; i++) begin
            m_lvl[i]  = 3'd0;
            m_pend[i] = 1'b0;
        end
        e_valid = 1'b0;
        e_vec   = 16'h0000;
        e_mask  = 1'b0;
        e_idx   = 0;
        repeat (2) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        step("R1");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; src_irq = '0;
        rst_req = 0; dbg_req = 0; wdt_req = 0; zdiv_req = 0; brk_req = 0;
        cpu_ipl = '0; int_dis = 1'b0; ack = 1'b0;
        do_reset();

        // R2 R3 R4: every source, every level, every processor level; then cancel (R9)
        for (int i = 0; i < 16; i++) begin
            for (int l = 0; l < 8; l++) begin
                for (int p = 0; p < 8; p++) begin
                    cpu_ipl = 3'(p);
                    wr(i, {1'b1, 3'(l)}, "R2 R3 R4");
                    wr(i, 4'b0000, "R9");
                end
            end
        end

        // R3: global disable hides all pending maskable sources
        cpu_ipl = 3'd0;
        int_dis = 1'b1;
        for (int i = 0; i < 16; i++) wr(i, 4'b1111, "R3");
        int_dis = 1'b0;
        step("R3");
        drain("R7");
        step("R10");

        // R5: equal levels, higher index first
        for (int i = 0; i < 16; i++) wr(i, 4'b1101, "R2");
        drain("R5");

        // R5: mixed levels, served above ipl 2, then the rest
        for (int i = 0; i < 16; i++) wr(i, {1'b1, 3'((i * 5 + 3) % 8)}, "R2");
        cpu_ipl = 3'd2;
        step("R3");
        drain("R5");
        step("R10");
        cpu_ipl = 3'd0;
        step("R3");
        drain("R5");
        for (int i = 0; i < 16; i++) wr(i, 4'b0000, "R9");

        // R6: every combination of special sources, masked and unmasked; ack on special keeps flag (R7)
        wr(4, 4'b1110, "R2");
        for (int m = 0; m < 32; m++) begin
            {rst_req, dbg_req, wdt_req, zdiv_req, brk_req} = 5'(m);
            int_dis = ((m % 3) == 0);
            cpu_ipl = 3'(m % 8);
            ack     = m[1];
            step("R6");
        end
        {rst_req, dbg_req, wdt_req, zdiv_req, brk_req} = 5'd0;
        int_dis = 1'b0;
        cpu_ipl = 3'd0;
        step("R7");
        drain("R7");

        // R7: ack with nothing shown changes nothing
        wr(9, 4'b0011, "R2");
        ack = 1'b1;
        step("R7");
        cpu_ipl = 3'd0;
        step("R10");

        // R8: hardware pulse sets, and beats a same-cycle cancel or acknowledge
        src_irq[9] = 1'b1;
        step("R8");
        wr_en = 1'b1; wr_sel = 4'd9; wr_data = 4'b0011; src_irq[9] = 1'b1;
        step("R8");
        ack = 1'b1; src_irq[9] = 1'b1;
        step("R8");
        ack = 1'b1;
        step("R7");
        step("R10");

        // R1: reset mid-run clears pending state
        wr(2, 4'b1111, "R2");
        wr(12, 4'b1100, "R2");
        do_reset();
        step("R1");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule